// File: doc/BRIEF.md
# Turn-Model Adaptive Route Selector

This block computes the output port for one hop of a packet in a two-dimensional mesh router. From the coordinates of the current node and of the destination, it finds the directions that bring the packet closer, called the productive directions. It then removes the directions that the selected turn-restriction policy forbids at this point of the route. From the directions that remain it picks one, and it uses per-link busy flags (congestion or fault) to steer away from a flagged link when the policy leaves a choice. When the packet has arrived, the local ejection port is chosen.

Four policies are available: strict dimension order, west-first, north-last and negative-first. Each one forbids a set of turns that keeps the channel dependence graph free of cycles, so a mesh built from these routers cannot deadlock. Routing is always minimal. The result is registered, so it appears one clock after the request.

Direction names used throughout: +x is east, -x is west, +y is north, -y is south. Coordinates are unsigned and grow toward east and north.

Top module: `turn_route_sel`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0 and `out_port` is all zeros.
- R2: `out_valid` equals the `in_valid` of the previous cycle. When it is 1, exactly one bit of `out_port` is set (bit 0 local, bit 1 +x, bit 2 -x, bit 3 +y, bit 4 -y). When it is 0, `out_port` is zero.
- R3: If the destination equals the current node, `out_port` selects local (bit 0), whatever the busy flags and the policy.
- R4: A non-local choice is always productive: +x only if dst_x > cur_x, -x only if dst_x < cur_x, +y only if dst_y > cur_y, -y only if dst_y < cur_y.
- R5: With `policy` = 0 (dimension order), the x direction is chosen whenever dst_x differs from cur_x, even if that link is busy. The y direction is chosen only after x is done.
- R6: With `policy` = 1 (west-first), the -x port is chosen whenever dst_x < cur_x, even if it is busy. Otherwise any productive direction is eligible.
- R7: With `policy` = 2 (north-last), +y is chosen only when dst_x equals cur_x. Otherwise any productive direction other than +y is eligible.
- R8: With `policy` = 3 (negative-first), +x or +y is chosen only when neither dst_x < cur_x nor dst_y < cur_y holds. While a negative direction is productive, only the negative productive directions are eligible.
- R9: When more than one direction is eligible, an eligible one whose `link_busy` bit is clear is preferred (bit 0 +x, bit 1 -x, bit 2 +y, bit 3 -y). If both eligible directions are clear, the x direction wins.
- R10: If every eligible direction is flagged busy, the x direction is chosen when it is eligible, and the y direction otherwise.
- R11: Busy flags on directions that are not eligible have no effect on the choice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A route request is present this cycle |
| cur_x | input | COORD_W | X coordinate of this node |
| cur_y | input | COORD_W | Y coordinate of this node |
| dst_x | input | COORD_W | X coordinate of the destination |
| dst_y | input | COORD_W | Y coordinate of the destination |
| policy | input | 2 | Turn policy: 0 dimension order, 1 west-first, 2 north-last, 3 negative-first |
| link_busy | input | 4 | Busy or failed flag per output: +x, -x, +y, -y |
| out_valid | output | 1 | Registered request valid |
| out_port | output | 5 | One-hot chosen port: local, +x, -x, +y, -y |

## Verification
Destinations are placed in all four quadrants around a fixed node, on each axis, and on the node itself. Each placement is tried under every policy, so a wrong forbidden turn shows up as a port that differs from the model. The busy patterns are chosen for specific purposes: one flag on an eligible port tells adaptive choice apart from fixed order, all eligible ports flagged checks the default fallback, and flags only on ineligible ports show that those flags are ignored. Corner coordinates 0 and the maximum value exercise the unsigned comparison. A long pseudo-random run then compares every cycle, including idle cycles, against a behavioural model.

// File: rtl/route_pkg.sv
package route_pkg;
    localparam int NUM_DIR = 4;
    localparam int PORT_W  = NUM_DIR + 1;

    // direction bit positions inside productive, legal and busy masks
    localparam int D_PX = 0;
    localparam int D_MX = 1;
    localparam int D_PY = 2;
    localparam int D_MY = 3;

    typedef enum logic [1:0] {
        POL_DIM_ORDER  = 2'd0,
        POL_WEST_FIRST = 2'd1,
        POL_NORTH_LAST = 2'd2,
        POL_NEG_FIRST  = 2'd3
    } policy_e;

    typedef struct packed {
        logic              valid;
        logic [PORT_W-1:0] port;
    } sel_state_t;
endpackage

// File: rtl/rt_delta.sv
module rt_delta
    import route_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output logic [NUM_DIR-1:0] prod,
    output logic               at_dest
);
    localparam int NUM_AXES = NUM_DIR / 2;

    logic [COORD_W-1:0] here  [NUM_AXES];
    logic [COORD_W-1:0] there [NUM_AXES];

    assign here[0]  = cur_x;
    assign here[1]  = cur_y;
    assign there[0] = dst_x;
    assign there[1] = dst_y;

    // per axis: even bit is the plus direction, odd bit the minus one
    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        assign prod[2*a]   = there[a] > here[a];
        assign prod[2*a+1] = there[a] < here[a];
    end

    assign at_dest = ~|prod;
endmodule

// File: rtl/rt_turn_mask.sv
module rt_turn_mask
    import route_pkg::*;
(
    input  policy_e            policy,
    input  logic [NUM_DIR-1:0] prod,
    output logic [NUM_DIR-1:0] legal
);
    localparam logic [NUM_DIR-1:0] X_DIRS   = (NUM_DIR'(1) << D_PX) | (NUM_DIR'(1) << D_MX);
    localparam logic [NUM_DIR-1:0] NEG_DIRS = (NUM_DIR'(1) << D_MX) | (NUM_DIR'(1) << D_MY);
    localparam logic [NUM_DIR-1:0] NORTH    = NUM_DIR'(1) << D_PY;
    localparam logic [NUM_DIR-1:0] WEST     = NUM_DIR'(1) << D_MX;

    logic x_left;
    logic [NUM_DIR-1:0] neg_left;

    always_comb begin
        x_left   = |(prod & X_DIRS);
        neg_left = prod & NEG_DIRS;
        legal    = prod;
        unique case (policy)
            POL_DIM_ORDER: begin
                if (x_left) legal = prod & X_DIRS;
            end
            POL_WEST_FIRST: begin
                if (prod[D_MX]) legal = WEST;
            end
            POL_NORTH_LAST: begin
                if (prod[D_PY] && x_left) legal = prod & ~NORTH;
            end
            POL_NEG_FIRST: begin
                if (|neg_left) legal = neg_left;
            end
            default: legal = prod;
        endcase
    end
endmodule

// File: rtl/rt_pick.sv
module rt_pick
    import route_pkg::*;
(
    input  logic [NUM_DIR-1:0] legal,
    input  logic [NUM_DIR-1:0] busy,
    input  logic               at_dest,
    output logic [PORT_W-1:0]  port
);
    logic [NUM_DIR-1:0] free;
    logic [NUM_DIR-1:0] pool;
    logic [NUM_DIR-1:0] first;
    logic               taken;

    always_comb begin
        free  = legal & ~busy;
        pool  = (|free) ? free : legal;
        first = '0;
        taken = 1'b0;
        // lower index first: x directions precede y directions
        for (int i = 0; i < NUM_DIR; i++) begin
            if (pool[i] && !taken) begin
                first[i] = 1'b1;
                taken    = 1'b1;
            end
        end
        port = at_dest ? PORT_W'(1) : {first, 1'b0};
    end
endmodule

// File: rtl/turn_route_sel.sv
module turn_route_sel
    import route_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [1:0]         policy,
    input  logic [3:0]         link_busy,
    output logic               out_valid,
    output logic [4:0]         out_port
);
    logic [NUM_DIR-1:0] prod_w;
    logic [NUM_DIR-1:0] legal_w;
    logic [PORT_W-1:0]  pick_w;
    logic               at_dest_w;
    sel_state_t         st_d, st_q;

    rt_delta #(.COORD_W(COORD_W)) u_delta (
        .cur_x   (cur_x),
        .cur_y   (cur_y),
        .dst_x   (dst_x),
        .dst_y   (dst_y),
        .prod    (prod_w),
        .at_dest (at_dest_w)
    );

    rt_turn_mask u_mask (
        .policy (policy_e'(policy)),
        .prod   (prod_w),
        .legal  (legal_w)
    );

    rt_pick u_pick (
        .legal   (legal_w),
        .busy    (link_busy),
        .at_dest (at_dest_w),
        .port    (pick_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.port  = in_valid ? pick_w : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_port  = st_q.port;
endmodule

// File: rtl/turn_route_sel_chk.sv
module turn_route_sel_chk #(
    parameter int COORD_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [COORD_W-1:0] cur_x,
    input logic [COORD_W-1:0] cur_y,
    input logic [COORD_W-1:0] dst_x,
    input logic [COORD_W-1:0] dst_y,
    input logic [1:0]         policy,
    input logic [3:0]         link_busy,
    input logic               out_valid,
    input logic [4:0]         out_port
);
    logic               p_valid;
    logic [COORD_W-1:0] p_cx, p_cy, p_dx, p_dy;
    logic [1:0]         p_pol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            p_cx <= '0; p_cy <= '0; p_dx <= '0; p_dy <= '0;
            p_pol <= '0;
        end else begin
            p_valid <= in_valid;
            p_cx <= cur_x; p_cy <= cur_y; p_dx <= dst_x; p_dy <= dst_y;
            p_pol <= policy;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == p_valid);
    // R2
    port_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid ? ($countones(out_port) == 1) : (out_port == '0));
    // R3
    local_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && p_cx == p_dx && p_cy == p_dy) |-> out_port[0]);
    // R4
    productive_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((!out_port[1] || p_dx > p_cx) && (!out_port[2] || p_dx < p_cx) &&
                       (!out_port[3] || p_dy > p_cy) && (!out_port[4] || p_dy < p_cy)));
    // R5
    dim_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && p_pol == 2'd0 && p_dx != p_cx) |-> (out_port[1] || out_port[2]));
    // R6
    west_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && p_pol == 2'd1 && p_dx < p_cx) |-> out_port[2]);
    // R7
    north_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && p_pol == 2'd2 && out_port[3]) |-> (p_dx == p_cx));
    // R8
    neg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && p_pol == 2'd3 && (out_port[1] || out_port[3])) |->
        !(p_dx < p_cx || p_dy < p_cy));
endmodule

bind turn_route_sel turn_route_sel_chk #(.COORD_W(COORD_W)) u_chk (.*);

// File: tb/sim_turn_route_sel.sv
`timescale 1ns/1ps
module sim_turn_route_sel;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [CW-1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
    logic [1:0]    policy = '0;
    logic [3:0]    link_busy = '0;
    logic          out_valid;
    logic [4:0]    out_port;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic       exp_valid = 1'b0;
    logic [4:0] exp_port = '0;
    string      exp_tag = "R1";

    always #2.5 clk = ~clk;

    turn_route_sel #(.COORD_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .policy(policy), .link_busy(link_busy),
        .out_valid(out_valid), .out_port(out_port)
    );

    // behavioural model: ports 1 +x, 2 -x, 3 +y, 4 -y; busy bit = port-1
    function automatic logic [4:0] model(int cx, int cy, int tx, int ty, int pol, logic [3:0] bz);
        int ex, ey;
        int cand[$];
        ex = tx - cx;
        ey = ty - cy;
        if (ex == 0 && ey == 0) return 5'b00001;
        case (pol)
            0: begin
                if (ex > 0) cand.push_back(1);
                else if (ex < 0) cand.push_back(2);
                else if (ey > 0) cand.push_back(3);
                else cand.push_back(4);
            end
            1: begin
                if (ex < 0) cand.push_back(2);
                else begin
                    if (ex > 0) cand.push_back(1);
                    if (ey > 0) cand.push_back(3);
                    if (ey < 0) cand.push_back(4);
                end
            end
            2: begin
                if (ex > 0) cand.push_back(1);
                if (ex < 0) cand.push_back(2);
                if (ey < 0) cand.push_back(4);
                if (ey > 0 && ex == 0) cand.push_back(3);
            end
            default: begin
                if (ex < 0 || ey < 0) begin
                    if (ex < 0) cand.push_back(2);
                    if (ey < 0) cand.push_back(4);
                end else begin
                    if (ex > 0) cand.push_back(1);
                    if (ey > 0) cand.push_back(3);
                end
            end
        endcase
        foreach (cand[i]) if (!bz[cand[i]-1]) return 5'b1 << cand[i];
        return 5'b1 << cand[0];
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== exp_valid || out_port !== exp_port) begin
            errors++;
            $display("FAIL %s: valid=%0b port=%05b expected valid=%0b port=%05b",
                     exp_tag, out_valid, out_port, exp_valid, exp_port);
        end
    endtask

    // compare the result of the previous request, then present a new one
    task automatic step(bit v, int cx, int cy, int tx, int ty, int pol, logic [3:0] bz, string tag);
        @(negedge clk);
        compare();
        in_valid  = v;
        cur_x     = CW'(cx); cur_y = CW'(cy);
        dst_x     = CW'(tx); dst_y = CW'(ty);
        policy    = 2'(pol);
        link_busy = bz;
        exp_valid = v;
        exp_port  = v ? model(cx, cy, tx, ty, pol, bz) : 5'b0;
        exp_tag   = tag;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        exp_tag = "R1";
        compare();                      // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        compare();                      // R1 first cycle after reset
        // R3 arrival beats every flag and policy
        step(1, 5, 5, 5, 5, 0, 4'hF, "R3");
        step(1, 5, 5, 5, 5, 3, 4'hF, "R3");
        // R2 idle cycle clears port
        step(0, 5, 5, 8, 2, 0, 4'h0, "R2");
        // R5 dimension order
        step(1, 5, 5, 8, 2, 0, 4'b0001, "R5");
        step(1, 5, 5, 5, 9, 0, 4'b0100, "R5");
        step(1, 5, 5, 2, 9, 0, 4'b0010, "R5");
        // R6 west-first
        step(1, 5, 5, 2, 9, 1, 4'b0010, "R6");
        step(1, 5, 5, 8, 9, 1, 4'b0000, "R9");
        step(1, 5, 5, 8, 9, 1, 4'b0001, "R9");
        step(1, 5, 5, 8, 2, 1, 4'b1001, "R10");
        step(1, 5, 5, 8, 2, 1, 4'b0001, "R6");
        // R7 north-last
        step(1, 5, 5, 8, 9, 2, 4'b0001, "R7");
        step(1, 5, 5, 2, 2, 2, 4'b0010, "R9");
        step(1, 5, 5, 5, 9, 2, 4'b0100, "R7");
        step(1, 5, 5, 2, 9, 2, 4'b0110, "R7");
        step(1, 5, 5, 8, 5, 2, 4'hF, "R10");
        // R8 negative-first
        step(1, 5, 5, 2, 9, 3, 4'b0010, "R8");
        step(1, 5, 5, 8, 2, 3, 4'b1000, "R8");
        step(1, 5, 5, 2, 2, 3, 4'b0010, "R9");
        step(1, 5, 5, 2, 2, 3, 4'b1010, "R10");
        step(1, 5, 5, 8, 9, 3, 4'b0001, "R8");
        // R11 flags on ineligible links
        step(1, 5, 5, 8, 5, 0, 4'b1110, "R11");
        step(1, 5, 5, 8, 9, 1, 4'b1010, "R11");
        step(1, 5, 5, 2, 9, 3, 4'b1101, "R11");
        // R4 corner coordinates
        step(1, 0, 15, 15, 0, 1, 4'b0001, "R4");
        step(1, 15, 0, 0, 15, 2, 4'b0010, "R4");
        step(1, 0, 0, 15, 15, 3, 4'b0000, "R4");
        step(0, 0, 0, 0, 0, 0, 4'h0, "R2");
        // R4 pseudo-random sweep across all policies
        for (int n = 0; n < 600; n++) begin
            step(($urandom % 5) != 0, $urandom % 16, $urandom % 16, $urandom % 16,
                 $urandom % 16, $urandom % 4, 4'($urandom), "R4");
        end
        @(negedge clk);
        compare();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule